// File: doc/BRIEF.md
# Handshaked I/O-Page Register Slave

This block is a small bank of 16-bit device registers that answers on an 18-bit-address asynchronous bus. The bus strobes arrive already synchronized to the local clock. The block decodes a short, word-aligned address window in the top 8 KB of the 256 KB space and reads the two cycle-control bits as one of four transfer kinds: a plain read, a read that opens a read-modify-write, a word write and a byte write. It acknowledges each cycle it claims by raising a slave strobe in answer to the master strobe. It keeps that strobe up until the master lets go.

Each byte of every register carries its own stored parity bit. A test input can poison the parity stored by a write. A later read of that word reports a parity error beside the returned data. Any address outside the window gets no answer at all, so the master's own timeout sees a missing device. After a read that opens a read-modify-write, the block locks out further reads until a write closes the pair.

Top module: `busslave_regs`

## Requirements
- R1: After reset, `ssyn_o`, `perr_o` and `rdata_o` are 0, and every register reads back as 0 with no parity error.
- R2: `ctl_i` selects the transfer: 2'b00 is a read, 2'b01 is a read that opens a read-modify-write, 2'b10 is a word write, 2'b11 is a byte write.
- R3: Only addresses from `BASE` to `BASE + 2*NREGS - 1` are claimed; register index = (addr - BASE) >> 1. Any other address gets no `ssyn_o` and changes no register.
- R4: With the block idle, `msyn_i` sampled high on a claimed cycle raises `ssyn_o` one clock later. `ssyn_o` stays high while `msyn_i` is high, and falls one clock after `msyn_i` is sampled low.
- R5: On a read of either kind, `rdata_o` holds the addressed register's contents while `ssyn_o` is high.
- R6: A word write stores all 16 bits of `wdata_i`. Address bit 0 is ignored.
- R7: A byte write with address bit 0 = 0 stores `wdata_i[7:0]` into bits 7:0. With address bit 0 = 1 it stores `wdata_i[15:8]` into bits 15:8. The other byte is left unchanged.
- R8: Every write stores one parity bit per written byte, inverted when `badpar_i` is 1. A read raises `perr_o` together with `ssyn_o` when either byte's stored parity mismatches. A clean rewrite of the byte clears the error.
- R9: After a read-pause cycle completes, reads of either kind get no `ssyn_o` until a word or byte write in the window is acknowledged. That write closes the read-modify-write pair.
- R10: `perr_o` is 0 on write cycles and whenever `ssyn_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 18 | Bus address |
| ctl_i | input | 2 | Cycle-control bits {C1,C0} |
| msyn_i | input | 1 | Synchronized master strobe |
| wdata_i | input | 16 | Write data |
| badpar_i | input | 1 | Store inverted parity on this write |
| rdata_o | output | 16 | Read data |
| ssyn_o | output | 1 | Slave strobe (acknowledge) |
| perr_o | output | 1 | Stored parity error on a read |

## Verification
The assertions assume a well-behaved master. It keeps `addr_i`, `ctl_i` and `wdata_i` steady while `msyn_i` is high, and it drops `msyn_i` only to end a cycle, either after `ssyn_o` or after its own timeout. The stimulus task follows that discipline on every cycle. It changes the inputs only while the strobe is low, and it waits out a fixed timeout before giving up on a cycle that gets no answer. The random addresses mix in-window targets with other I/O-page addresses. The directed cases cover the window edges, both byte lanes, poisoned parity and the read-modify-write lockout.

// File: rtl/busslave_regs.sv
module busslave_regs #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NREGS = 8,
  parameter logic [ADDR_W-1:0] BASE = 18'h3FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ctl_i,
  input  logic              msyn_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              badpar_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ssyn_o,
  output logic              perr_o
);
  localparam int IDX_W = $clog2(NREGS);
  localparam int SPAN = 2 * NREGS;
  localparam int HB = 8;
  localparam logic [1:0] CT_RD = 2'b00, CT_RDP = 2'b01, CT_WR = 2'b10, CT_WRB = 2'b11;

  logic [DATA_W-1:0] mem [NREGS];
  logic [1:0]        par [NREGS];
  logic              busy, pause;

  wire [ADDR_W-1:0] off = addr_i - BASE;
  wire              hit = (addr_i >= BASE) && (off < ADDR_W'(SPAN));
  wire [IDX_W-1:0]  idx = off[IDX_W:1];
  wire              take = msyn_i && hit && (ctl_i[1] || !pause);
  wire [DATA_W-1:0] cur = mem[idx];
  wire              bad = (^cur[HB-1:0] != par[idx][0]) || (^cur[DATA_W-1:HB] != par[idx][1]);
  wire              plo = ^wdata_i[HB-1:0] ^ badpar_i;
  wire              phi = ^wdata_i[DATA_W-1:HB] ^ badpar_i;

  assign ssyn_o = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pause <= 1'b0;
      perr_o <= 1'b0;
      rdata_o <= '0;
      for (int i = 0; i < NREGS; i++) begin
        mem[i] <= '0;
        par[i] <= '0;
      end
    end else if (!busy) begin
      if (take) begin
        busy <= 1'b1;
        case (ctl_i)
          CT_RD, CT_RDP: begin
            rdata_o <= cur;
            perr_o <= bad;
            if (ctl_i == CT_RDP) pause <= 1'b1;
          end
          CT_WR: begin
            mem[idx] <= wdata_i;
            par[idx] <= {phi, plo};
            pause <= 1'b0;
          end
          default: begin
            if (addr_i[0]) begin
              mem[idx][DATA_W-1:HB] <= wdata_i[DATA_W-1:HB];
              par[idx][1] <= phi;
            end else begin
              mem[idx][HB-1:0] <= wdata_i[HB-1:0];
              par[idx][0] <= plo;
            end
            pause <= 1'b0;
          end
        endcase
      end
    end else if (!msyn_i) begin
      busy <= 1'b0;
      perr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/busslave_regs_chk.sv
module busslave_regs_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int NREGS = 8,
  parameter logic [ADDR_W-1:0] BASE = 18'h3FF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        ctl_i,
  input logic              msyn_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ssyn_o,
  input logic              perr_o
);
  wire [ADDR_W-1:0] rel = addr_i - BASE;
  wire in_win = (addr_i >= BASE) && (rel < ADDR_W'(2 * NREGS));

  assert_ack_follows_msyn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssyn_o) |-> $past(msyn_i));
  assert_ack_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ssyn_o && msyn_i |=> ssyn_o);
  assert_ack_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ssyn_o && !msyn_i |=> !ssyn_o);
  assert_window_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssyn_o) |-> $past(in_win));
  assert_perr_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> ssyn_o);
  assert_no_perr_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssyn_o) && $past(ctl_i[1]) |-> !perr_o);
  assert_rdata_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ssyn_o && $past(ssyn_o) |-> $stable(rdata_o));
endmodule

bind busslave_regs busslave_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ctl_i(ctl_i), .msyn_i(msyn_i),
  .rdata_o(rdata_o), .ssyn_o(ssyn_o), .perr_o(perr_o));

// File: tb/sim_busslave_regs.sv
module sim_busslave_regs;
  localparam int NREGS = 8;
  localparam logic [17:0] BASE = 18'h3FF00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0] ctl = '0;
  logic msyn = 1'b0, badpar = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic ssyn, perr;
  int checks = 0, errors = 0, cyc = 0;

  logic [15:0] mdat [NREGS];
  logic [1:0]  mbad [NREGS];
  bit          mpause;

  always #2 clk = ~clk;

  busslave_regs u0 (.clk(clk), .rst_n(rst_n), .addr_i(addr), .ctl_i(ctl), .msyn_i(msyn),
    .wdata_i(wdata), .badpar_i(badpar), .rdata_o(rdata), .ssyn_o(ssyn), .perr_o(perr));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [17:0] a);
    return (a >= BASE) && (a - BASE < 18'(2 * NREGS));
  endfunction

  task automatic bus(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d, input bit bad);
    int idx = int'((a - BASE) >> 1);
    bit exp_ack = in_win(a) && (c[1] || !mpause);
    @(negedge clk);
    addr = a; ctl = c; wdata = d; badpar = bad; msyn = 1'b1;
    @(negedge clk);
    chk(ssyn === exp_ack, exp_ack ? "R4" : (in_win(a) ? "R9" : "R3"), "ack", 32'(ssyn), 32'(exp_ack));
    if (exp_ack) begin
      if (!c[1]) begin
        chk(rdata === mdat[idx], "R5", "read data", 32'(rdata), 32'(mdat[idx]));
        chk(perr === (|mbad[idx]), "R8", "parity flag", 32'(perr), 32'(|mbad[idx]));
        if (c == 2'b01) mpause = 1'b1;
      end else begin
        chk(perr === 1'b0, "R10", "perr on write", 32'(perr), 0);
        if (c == 2'b10) begin mdat[idx] = d; mbad[idx] = {bad, bad}; end
        else if (a[0]) begin mdat[idx][15:8] = d[15:8]; mbad[idx][1] = bad; end
        else begin mdat[idx][7:0] = d[7:0]; mbad[idx][0] = bad; end
        mpause = 1'b0;
      end
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(ssyn === 1'b1, "R4", "ack hold", 32'(ssyn), 1);
      end
    end else begin
      repeat (3) begin
        @(negedge clk);
        chk(ssyn === 1'b0, "R3", "no ack", 32'(ssyn), 0);
      end
    end
    msyn = 1'b0;
    @(negedge clk);
    chk(ssyn === 1'b0, "R4", "ack release", 32'(ssyn), 0);
    chk(perr === 1'b0, "R10", "perr idle", 32'(perr), 0);
  endtask

  task automatic expect_read(input logic [17:0] a, input logic [15:0] v, input string req);
    int idx = int'((a - BASE) >> 1);
    chk(mdat[idx] === v, req, "model value", 32'(mdat[idx]), 32'(v));
    bus(a, 2'b00, 16'h0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NREGS; i++) begin mdat[i] = '0; mbad[i] = '0; end
    mpause = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ssyn === 1'b0 && perr === 1'b0 && rdata === 16'h0, "R1", "reset outputs", {ssyn, perr, rdata}, 0);
    expect_read(BASE, 16'h0, "R1");
    expect_read(BASE + 18'(2 * NREGS - 2), 16'h0, "R1");
    // R3 window edges, writes outside must not land
    bus(BASE - 18'd2, 2'b10, 16'hDEAD, 1'b0);
    bus(BASE + 18'(2 * NREGS), 2'b10, 16'hDEAD, 1'b0);
    bus(BASE - 18'd1, 2'b00, 16'h0, 1'b0);
    expect_read(BASE, 16'h0, "R3");
    expect_read(BASE + 18'(2 * NREGS - 1), 16'h0, "R3");
    // R2 R6 word write
    bus(BASE + 18'd5, 2'b10, 16'hBEEF, 1'b0);
    expect_read(BASE + 18'd4, 16'hBEEF, "R6");
    // R7 byte lanes
    bus(BASE + 18'd4, 2'b11, 16'hAA12, 1'b0);
    expect_read(BASE + 18'd4, 16'hBE12, "R7");
    bus(BASE + 18'd5, 2'b11, 16'h34BB, 1'b0);
    expect_read(BASE + 18'd4, 16'h3412, "R7");
    // R8 parity poisoning and repair
    bus(BASE + 18'd2, 2'b11, 16'h0077, 1'b1);
    bus(BASE + 18'd2, 2'b00, 16'h0, 1'b0);
    bus(BASE + 18'd2, 2'b11, 16'h0077, 1'b0);
    bus(BASE + 18'd2, 2'b00, 16'h0, 1'b0);
    chk(mbad[1] === 2'b00, "R8", "parity repaired in model", 32'(mbad[1]), 0);
    // R9 read-modify-write lockout
    bus(BASE + 18'd6, 2'b01, 16'h0, 1'b0);
    bus(BASE + 18'd6, 2'b00, 16'h0, 1'b0);
    bus(BASE + 18'd8, 2'b01, 16'h0, 1'b0);
    bus(BASE + 18'd7, 2'b11, 16'h5500, 1'b0);
    bus(BASE + 18'd6, 2'b00, 16'h0, 1'b0);
    chk(mpause === 1'b0, "R9", "pause closed", 32'(mpause), 0);
    // random traffic
    for (int n = 0; n < 500; n++) begin
      logic [17:0] a;
      if ($urandom % 6 != 0) a = BASE + 18'($urandom % (2 * NREGS + 2)) - 18'd1;
      else a = {5'b11111, 13'($urandom)};
      bus(a, 2'($urandom), 16'($urandom), ($urandom % 6) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule